// File: doc/BRIEF.md
# Scaled-Index Effective Address Generator

This block forms the effective address for a memory operand of a 32-bit register-memory processor. Each request carries a base register value, an index register value, a two-bit scale selector, a displacement and a form code. The form code picks one of four address shapes. The index may be multiplied by 1, 2, 4 or 8 through a left shift. The displacement is either a short 8-bit immediate that is sign-extended or a full 32-bit immediate. All terms go through one three-input adder, and the sum wraps at 2^32.

The result is registered, so it appears one cycle after the request. A small two-state controller produces the output valid flag. In state `ST_IDLE` no result is presented. In state `ST_VALID` the registered result is presented. An accepted request (`in_valid` high) moves the controller to `ST_VALID` from either state. A cycle without a request moves it to `ST_IDLE` from either state. In load-effective-address mode the sum is flagged as a register result, and no memory request is raised. Alignment is never checked or forced.

Top module: `agu_ea`

## Requirements
- R1: After reset `out_valid`, `out_mem_req` and `out_lea` are 0 and the controller is in `ST_IDLE`. A request with `in_valid` high yields `out_valid` high on the next cycle. A cycle with `in_valid` low yields `out_valid` low on the next cycle.
- R2: Form code 0 (base plus displacement) gives base + displacement. The index and the scale are ignored.
- R3: Form code 1 (base plus index) gives base + index. The scale and the displacement are ignored.
- R4: Form code 2 (scaled index plus base) gives base + (index << scale), where scale values 0, 1, 2 and 3 multiply the index by 1, 2, 4 and 8. The displacement is ignored.
- R5: Form code 3 (scaled index plus base plus displacement) gives base + (index << scale) + displacement.
- R6: When `disp_wide` is 0, the displacement is `disp[7:0]` sign-extended to 32 bits, and `disp[31:8]` has no effect. When `disp_wide` is 1, all 32 bits of `disp` are used.
- R7: When `base_en` is 0 the base contributes zero. When `index_en` is 0 the index contributes zero.
- R8: The sum wraps modulo 2^32, and no overflow indication exists.
- R9: While `out_valid` is 1, a request made with `lea` = 1 gives `out_lea` = 1 and `out_mem_req` = 0, and a request made with `lea` = 0 gives `out_mem_req` = 1 and `out_lea` = 0. While `out_valid` is 0, both flags are 0.
- R10: Low address bits pass through unchanged, so odd and unaligned addresses come out exactly as computed.
- R11: `out_addr` holds its value through cycles with no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| form | input | 2 | Address form code (0..3) |
| base_en | input | 1 | Base operand present |
| base | input | 32 | Base register value |
| index_en | input | 1 | Index operand present |
| index | input | 32 | Index register value |
| scale | input | 2 | Index shift amount |
| disp_wide | input | 1 | 1: 32-bit displacement, 0: sign-extended 8-bit |
| disp | input | 32 | Displacement immediate |
| lea | input | 1 | Address-only request |
| out_valid | output | 1 | Registered result valid |
| out_addr | output | 32 | Registered effective address |
| out_mem_req | output | 1 | Memory access wanted |
| out_lea | output | 1 | Address is a register result |

## Verification
The assertions check the timing of the valid flag on every cycle, along with the exclusive relationship between the memory-request flag and the address-only flag, address holding in idle cycles, and two arithmetic paths: short-displacement sign extension and zeroing of absent operands. The directed scenarios are needed to show the full arithmetic of every form across the four scales. They also show wrap-around at 2^32, that unaligned low bits survive, and that the ignored fields really have no effect.

// File: rtl/agu_ea_pkg.sv
package agu_ea_pkg;
    typedef enum logic [1:0] {
        FORM_BD   = 2'd0,
        FORM_BI   = 2'd1,
        FORM_BSI  = 2'd2,
        FORM_BSID = 2'd3
    } agu_form_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_VALID = 1'b1
    } agu_state_e;
endpackage

// File: rtl/agu_disp_ext.sv
module agu_disp_ext #(
    parameter int AW      = 32,
    parameter int SHORT_W = 8
) (
    input  logic [AW-1:0] disp,
    input  logic          wide,
    output logic [AW-1:0] ext
);
    localparam int PAD_W = AW - SHORT_W;
    logic [AW-1:0] short_ext;

    generate
        if (PAD_W > 0) begin : g_pad
            assign short_ext = {{PAD_W{disp[SHORT_W-1]}}, disp[SHORT_W-1:0]};
        end else begin : g_nopad
            assign short_ext = disp;
        end
    endgenerate

    assign ext = wide ? disp : short_ext;
endmodule

// File: rtl/agu_index_scale.sv
module agu_index_scale #(
    parameter int AW      = 32,
    parameter int SCALE_W = 2
) (
    input  logic [AW-1:0]      idx,
    input  logic [SCALE_W-1:0] scale,
    output logic [AW-1:0]      scaled
);
    localparam int NSHIFT = 1 << SCALE_W;
    logic [AW-1:0] options [NSHIFT];

    generate
        for (genvar s = 0; s < NSHIFT; s++) begin : g_shift
            assign options[s] = idx << s;
        end
    endgenerate

    assign scaled = options[scale];
endmodule

// File: rtl/agu_sum3.sv
module agu_sum3 #(
    parameter int AW = 32
) (
    input  logic [AW-1:0] a,
    input  logic [AW-1:0] b,
    input  logic [AW-1:0] c,
    output logic [AW-1:0] sum
);
    // carries beyond AW are dropped: modulo 2^AW
    assign sum = a + b + c;
endmodule

// File: rtl/agu_ea.sv
module agu_ea
    import agu_ea_pkg::*;
#(
    parameter int AW      = 32,
    parameter int SHORT_W = 8,
    parameter int SCALE_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [1:0]         form,
    input  logic               base_en,
    input  logic [AW-1:0]      base,
    input  logic               index_en,
    input  logic [AW-1:0]      index,
    input  logic [SCALE_W-1:0] scale,
    input  logic               disp_wide,
    input  logic [AW-1:0]      disp,
    input  logic               lea,
    output logic               out_valid,
    output logic [AW-1:0]      out_addr,
    output logic               out_mem_req,
    output logic               out_lea
);
    agu_form_e  form_e;
    agu_state_e state_q, state_d;

    logic [AW-1:0] disp_ext, idx_scaled;
    logic [AW-1:0] base_term, idx_term, disp_term, ea_sum;
    logic [AW-1:0] addr_q;
    logic          lea_q;

    assign form_e = agu_form_e'(form);

    agu_disp_ext #(.AW(AW), .SHORT_W(SHORT_W)) u_disp (
        .disp (disp),
        .wide (disp_wide),
        .ext  (disp_ext)
    );

    agu_index_scale #(.AW(AW), .SCALE_W(SCALE_W)) u_scale (
        .idx    (index),
        .scale  (scale),
        .scaled (idx_scaled)
    );

    always_comb begin
        base_term = base_en ? base : '0;
        idx_term  = '0;
        disp_term = '0;
        unique case (form_e)
            FORM_BD:   disp_term = disp_ext;
            FORM_BI:   idx_term  = index_en ? index : '0;
            FORM_BSI:  idx_term  = index_en ? idx_scaled : '0;
            FORM_BSID: begin
                idx_term  = index_en ? idx_scaled : '0;
                disp_term = disp_ext;
            end
            default: ;
        endcase
    end

    agu_sum3 #(.AW(AW)) u_sum (
        .a   (base_term),
        .b   (idx_term),
        .c   (disp_term),
        .sum (ea_sum)
    );

    // controller: next state
    always_comb begin
        unique case (state_q)
            ST_IDLE:  state_d = in_valid ? ST_VALID : ST_IDLE;
            ST_VALID: state_d = in_valid ? ST_VALID : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // controller: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            lea_q  <= 1'b0;
        end else if (in_valid) begin
            addr_q <= ea_sum;
            lea_q  <= lea;
        end
    end

    // controller: outputs
    always_comb begin
        out_addr    = addr_q;
        out_valid   = 1'b0;
        out_mem_req = 1'b0;
        out_lea     = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_VALID: begin
                out_valid   = 1'b1;
                out_mem_req = !lea_q;
                out_lea     = lea_q;
            end
            default: ;
        endcase
    end

    a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r1_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    a_r9_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_mem_req != out_lea));
    a_r9_flags_need_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (!out_mem_req && !out_lea));
    a_r9_lea_no_req: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && lea |=> out_lea && !out_mem_req);
    a_r11_addr_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_addr));
    a_r6_short_disp: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && form == 2'd0 && !base_en && !disp_wide |=>
        out_addr == {{(AW-SHORT_W){$past(disp[SHORT_W-1])}}, $past(disp[SHORT_W-1:0])});
    a_r7_no_operands: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && form == 2'd2 && !base_en && !index_en |=> out_addr == '0);
endmodule

// File: tb/tb_agu_ea.sv
`timescale 1ns/1ps
module tb_agu_ea;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  form = 2'd0;
    logic        base_en = 1'b0;
    logic [31:0] base = '0;
    logic        index_en = 1'b0;
    logic [31:0] index = '0;
    logic [1:0]  scale = 2'd0;
    logic        disp_wide = 1'b0;
    logic [31:0] disp = '0;
    logic        lea = 1'b0;
    logic        out_valid, out_mem_req, out_lea;
    logic [31:0] out_addr;

    int tests = 0;
    int fails = 0;

    always #4 clk = ~clk;

    agu_ea dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .form(form),
        .base_en(base_en), .base(base), .index_en(index_en), .index(index),
        .scale(scale), .disp_wide(disp_wide), .disp(disp), .lea(lea),
        .out_valid(out_valid), .out_addr(out_addr),
        .out_mem_req(out_mem_req), .out_lea(out_lea)
    );

    function automatic logic [31:0] model(input logic [1:0] f, input logic be,
        input logic [31:0] b, input logic ie, input logic [31:0] i,
        input logic [1:0] s, input logic dw, input logic [31:0] d);
        logic [63:0] acc;
        logic [63:0] dv;
        acc = be ? {32'd0, b} : 64'd0;
        if (dw) dv = {32'd0, d};
        else    dv = {32'd0, 32'(signed'(d[7:0]))};
        if (ie && f == 2'd1) acc = acc + {32'd0, i};
        if (ie && f >= 2'd2) acc = acc + {32'd0, i} * (64'd1 << s);
        if (f == 2'd0 || f == 2'd3) acc = acc + dv;
        return acc[31:0];
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic issue(input string req, input logic [1:0] f, input logic be,
        input logic [31:0] b, input logic ie, input logic [31:0] i,
        input logic [1:0] s, input logic dw, input logic [31:0] d, input logic l);
        @(negedge clk);
        form = f; base_en = be; base = b; index_en = ie; index = i;
        scale = s; disp_wide = dw; disp = d; lea = l; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk({req, " valid"}, {31'd0, out_valid}, 32'd1);
        chk({req, " addr"}, out_addr, model(f, be, b, ie, i, s, dw, d));
        chk({req, " mem_req"}, {31'd0, out_mem_req}, {31'd0, !l});
        chk({req, " lea"}, {31'd0, out_lea}, {31'd0, l});
    endtask

    task automatic t_reset();
        chk("R1 reset valid", {31'd0, out_valid}, 32'd0);
        chk("R1 reset mem_req", {31'd0, out_mem_req}, 32'd0);
        chk("R1 reset lea", {31'd0, out_lea}, 32'd0);
    endtask

    task automatic t_base_disp();
        issue("R2", 2'd0, 1, 32'h1000, 1, 32'hFFFF, 2'd3, 1, 32'h0000_0040, 0);
        chk("R2 value", out_addr, 32'h1040);
        issue("R6 short neg", 2'd0, 1, 32'h1000, 0, 0, 2'd0, 0, 32'h1234_56FC, 0);
        chk("R6 value", out_addr, 32'h0FFC);
        issue("R6 wide", 2'd0, 1, 32'h1000, 0, 0, 2'd0, 1, 32'h0001_0000, 0);
        chk("R6 wide value", out_addr, 32'h0001_1000);
    endtask

    task automatic t_base_index();
        issue("R3", 2'd1, 1, 32'h2000, 1, 32'h10, 2'd3, 1, 32'h5555, 0);
        chk("R3 value", out_addr, 32'h2010);
    endtask

    task automatic t_scaled();
        for (int s = 0; s < 4; s++) begin
            issue("R4", 2'd2, 1, 32'h100, 1, 32'h3, 2'(s), 1, 32'h777, 0);
            chk("R4 scale value", out_addr, 32'h100 + (32'h3 << s));
        end
    endtask

    task automatic t_full();
        issue("R5", 2'd3, 1, 32'h8000, 1, 32'h4, 2'd2, 0, 32'h0000_00F0, 0);
        chk("R5 value", out_addr, 32'h8000 + 32'h10 - 32'h10);
        issue("R5 wide", 2'd3, 1, 32'h10, 1, 32'h1, 2'd3, 1, 32'h100, 0);
    endtask

    task automatic t_enables();
        issue("R7 no base", 2'd3, 0, 32'hDEAD_BEEF, 1, 32'h2, 2'd1, 1, 32'h1, 0);
        chk("R7 no base value", out_addr, 32'h5);
        issue("R7 no index", 2'd3, 1, 32'h100, 0, 32'hFFFF, 2'd2, 1, 32'h1, 0);
        chk("R7 no index value", out_addr, 32'h101);
    endtask

    task automatic t_wrap();
        issue("R8", 2'd3, 1, 32'hFFFF_FFF0, 1, 32'h8, 2'd1, 1, 32'h4, 0);
        chk("R8 value", out_addr, 32'h0000_0004);
    endtask

    task automatic t_lea();
        issue("R9 lea", 2'd2, 1, 32'h40, 1, 32'h1, 2'd2, 0, 0, 1);
        issue("R9 mem", 2'd2, 1, 32'h40, 1, 32'h1, 2'd2, 0, 0, 0);
    endtask

    task automatic t_unaligned();
        issue("R10", 2'd3, 1, 32'h1001, 1, 32'h1, 2'd0, 0, 32'h2, 0);
        chk("R10 low bits", {30'd0, out_addr[1:0]}, 32'd0);
        chk("R10 value", out_addr, 32'h1004);
        issue("R10 odd", 2'd0, 1, 32'h2003, 0, 0, 2'd0, 0, 0, 0);
        chk("R10 odd value", out_addr, 32'h2003);
    endtask

    task automatic t_hold();
        logic [31:0] kept;
        issue("R11", 2'd0, 1, 32'hABCD, 0, 0, 2'd0, 1, 0, 1);
        kept = out_addr;
        base = 32'h1; disp = 32'h99;
        @(negedge clk);
        chk("R1 drop valid", {31'd0, out_valid}, 32'd0);
        chk("R9 idle flags", {30'd0, out_mem_req, out_lea}, 32'd0);
        repeat (2) @(negedge clk);
        chk("R11 hold", out_addr, kept);
    endtask

    task automatic t_back_to_back();
        @(negedge clk);
        form = 2'd0; base_en = 1; base = 32'h10; disp_wide = 1; disp = 32'h1; lea = 0;
        in_valid = 1'b1;
        @(negedge clk);
        chk("R1 b2b first", out_addr, 32'h11);
        base = 32'h20; lea = 1;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R1 b2b second", out_addr, 32'h21);
        chk("R1 b2b valid", {31'd0, out_valid}, 32'd1);
        chk("R9 b2b lea", {31'd0, out_lea}, 32'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_base_disp();
        t_base_index();
        t_scaled();
        t_full();
        t_enables();
        t_wrap();
        t_lea();
        t_unaligned();
        t_hold();
        t_back_to_back();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule